// File: doc/BRIEF.md
# Multi-channel timer PWM unit

A bank of independent timer channels, each driving one PWM pin. Every channel owns a 16-bit up-counter, a duty compare value, a period compare value and a small control register. A counter moves by one only on cycles where its channel is running and its own count-enable tick is high. The tick stands in for a divided clock. When the count equals the period, the next tick wraps the counter to zero. The pin sits at a programmable initial level until the count reaches the duty value, and then takes the opposite level until the period ends.

Two shared write-one registers start and stop individual counters. A synchronous register bus reads and writes every register. A write takes effect on the clock edge that samples it, and read data is combinational from the address. Turning the output off can act at once (abrupt mode) or can let the running period complete first.

Top module: `pwm_timer_bank`

## Requirements
- R1: After reset every channel register, counter and run flag is zero, and every pin is low.
- R2: A counter advances by one only on a clock edge where its channel is running and its tick input is high. Otherwise it holds.
- R3: On an advancing edge where the count equals the period value, the counter becomes 0, so a period lasts period+1 ticks.
- R4: With the output enabled (control bit 0) and the channel running, the pin is at the initial level while count < duty, and at the opposite level while duty <= count.
- R5: Control bit 2 selects the initial level (1 = high). While a channel is stopped, or its output is disabled outside a pending period end, the pin sits at the initial level.
- R6: When duty > period, the pin stays at the initial level for the whole period.
- R7: Writing the enable-set address (32 for 8 channels) starts channel n for each 1 in bit n. Writing the enable-clear address (33) stops it. Zero bits leave channels unchanged. Reading the enable-set address returns the run flags in bits N-1:0.
- R8: Software can write a channel counter directly, and the write has priority over counting.
- R9: Clearing the output enable with the abrupt-shutdown bit (control bit 1) set drives the pin to its initial level on the edge of the write.
- R10: Clearing the output enable with the abrupt bit clear keeps the waveform running until the counter wraps. From that edge on, the pin holds the initial level.
- R11: Channel registers sit at address 4*ch + k, where k = 0 is control, 1 is count, 2 is duty and 3 is period. Each register reads back its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | N_CH | Per-channel count-enable tick |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | clog2(N_CH)+3 | Register address |
| bus_wdata_i | input | CW | Write data |
| bus_rdata_o | output | CW | Read data (combinational) |
| pwm_o | output | N_CH | PWM pins |

## Verification
Period 4 with duty 2 is stepped tick by tick against a model counter. This separates a pin toggle at the duty match from one at the wrap, and it exposes a period that is off by one. The same waveform is then repeated with the initial level high to show that the level is inverted and not merely gated. Three further cases each test a separate path: a duty above the period, a stopped but enabled channel, and a tick-low stall. The two shutdown modes are driven in the middle of a period. Here the abrupt mode must drop the pin on the next edge, while the graceful mode must keep the waveform exactly to the wrap.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  typedef struct packed {
    logic init_high;  // bit 2
    logic abrupt;     // bit 1
    logic out_en;     // bit 0
  } ctrl_t;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CNT  = 2'd1,
    REG_DUTY = 2'd2,
    REG_PER  = 2'd3
  } ch_reg_e;
endpackage

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_timer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          ctrl_we_i,
  input  ctrl_t         ctrl_wdata_i,
  input  logic          cnt_we_i,
  input  logic          duty_we_i,
  input  logic          per_we_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          run_set_i,
  input  logic          run_clr_i,
  output ctrl_t         ctrl_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] duty_o,
  output logic [CW-1:0] per_o,
  output logic          run_o,
  output logic          pin_o
);
  ctrl_t         ctrl_q;
  logic [CW-1:0] cnt_q, duty_q, per_q;
  logic          run_q, drain_q;
  logic          step, at_end, active, drive;

  assign step   = tick_i && run_q;
  assign at_end = (cnt_q == per_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      duty_q <= '0;
      per_q  <= '0;
    end else begin
      if (ctrl_we_i) ctrl_q <= ctrl_wdata_i;
      if (duty_we_i) duty_q <= wdata_i;
      if (per_we_i)  per_q  <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (cnt_we_i) cnt_q <= wdata_i;
    else if (step)     cnt_q <= at_end ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        run_q <= 1'b0;
    else if (run_set_i) run_q <= 1'b1;
    else if (run_clr_i) run_q <= 1'b0;
  end

  // graceful shutdown: keep driving until the period wraps
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drain_q <= 1'b0;
    else if (!run_q || run_clr_i) drain_q <= 1'b0;
    else if (ctrl_we_i) begin
      if (ctrl_wdata_i.out_en || ctrl_wdata_i.abrupt) drain_q <= 1'b0;
      else drain_q <= ctrl_q.out_en || drain_q;
    end else if (step && at_end) drain_q <= 1'b0;
  end

  assign active = (cnt_q >= duty_q) && (duty_q <= per_q);
  assign drive  = run_q && (ctrl_q.out_en || drain_q) && active;
  assign pin_o  = ctrl_q.init_high ^ drive;

  assign ctrl_o = ctrl_q;
  assign cnt_o  = cnt_q;
  assign duty_o = duty_q;
  assign per_o  = per_q;
  assign run_o  = run_q;

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(tick_i && run_o) && !cnt_we_i) |=> $stable(cnt_o));
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && run_o && (cnt_o != per_o) && !cnt_we_i) |=> (cnt_o == $past(cnt_o) + 1'b1));
  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && run_o && (cnt_o == per_o) && !cnt_we_i) |=> (cnt_o == '0));
  p_stopped_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_o) |-> (pin_o == ctrl_o.init_high));
  p_duty_over_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_o > per_o) |-> (pin_o == ctrl_o.init_high));
  p_abrupt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && !ctrl_wdata_i.out_en && ctrl_wdata_i.abrupt) |=> (pin_o == ctrl_o.init_high));
endmodule

// File: rtl/pwm_bus_decode.sv
module pwm_bus_decode
  import pwm_timer_pkg::*;
#(
  parameter int N_CH = 8,
  parameter int CW   = 16,
  localparam int CHW = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int AW  = CHW + 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sel_i,
  input  logic                       we_i,
  input  logic [AW-1:0]              addr_i,
  input  logic [N_CH-1:0]            mask_i,
  output logic [N_CH-1:0]            ctrl_we_o,
  output logic [N_CH-1:0]            cnt_we_o,
  output logic [N_CH-1:0]            duty_we_o,
  output logic [N_CH-1:0]            per_we_o,
  output logic [N_CH-1:0]            set_o,
  output logic [N_CH-1:0]            clr_o,
  input  ctrl_t [N_CH-1:0]           ctrl_rd_i,
  input  logic  [N_CH-1:0][CW-1:0]   cnt_rd_i,
  input  logic  [N_CH-1:0][CW-1:0]   duty_rd_i,
  input  logic  [N_CH-1:0][CW-1:0]   per_rd_i,
  input  logic  [N_CH-1:0]           run_rd_i,
  output logic [CW-1:0]              rdata_o
);
  logic           glob;
  logic [CHW-1:0] ch_idx;
  ch_reg_e        reg_sel;
  logic           wr;

  assign glob    = addr_i[AW-1];
  assign ch_idx  = addr_i[AW-2:2];
  assign reg_sel = ch_reg_e'(addr_i[1:0]);
  assign wr      = sel_i && we_i;

  for (genvar c = 0; c < N_CH; c++) begin : g_dec
    logic hit;
    assign hit          = wr && !glob && (ch_idx == CHW'(c));
    assign ctrl_we_o[c] = hit && (reg_sel == REG_CTRL);
    assign cnt_we_o[c]  = hit && (reg_sel == REG_CNT);
    assign duty_we_o[c] = hit && (reg_sel == REG_DUTY);
    assign per_we_o[c]  = hit && (reg_sel == REG_PER);
  end

  assign set_o = (wr && glob && !addr_i[0]) ? mask_i : '0;
  assign clr_o = (wr && glob &&  addr_i[0]) ? mask_i : '0;

  always_comb begin
    rdata_o = '0;
    if (glob) begin
      if (!addr_i[0]) rdata_o = CW'(run_rd_i);
    end else if (int'(ch_idx) < N_CH) begin
      unique case (reg_sel)
        REG_CTRL: rdata_o = CW'(ctrl_rd_i[ch_idx]);
        REG_CNT:  rdata_o = cnt_rd_i[ch_idx];
        REG_DUTY: rdata_o = duty_rd_i[ch_idx];
        REG_PER:  rdata_o = per_rd_i[ch_idx];
        default:  rdata_o = '0;
      endcase
    end
  end

  p_one_cmd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_o & clr_o) == '0));
  p_no_glob_reg_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glob |-> ((ctrl_we_o | cnt_we_o | duty_we_o | per_we_o) == '0));
endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
  import pwm_timer_pkg::*;
#(
  parameter int N_CH = 8,
  parameter int CW   = 16,
  localparam int CHW = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int AW  = CHW + 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] tick_i,
  input  logic            bus_sel_i,
  input  logic            bus_we_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic [CW-1:0]   bus_wdata_i,
  output logic [CW-1:0]   bus_rdata_o,
  output logic [N_CH-1:0] pwm_o
);
  logic [N_CH-1:0]          ctrl_we, cnt_we, duty_we, per_we, set_v, clr_v, run_v;
  ctrl_t [N_CH-1:0]         ctrl_v;
  logic [N_CH-1:0][CW-1:0]  cnt_v, duty_v, per_v;
  ctrl_t                    ctrl_wdata;

  assign ctrl_wdata = ctrl_t'(bus_wdata_i[2:0]);

  pwm_bus_decode #(.N_CH(N_CH), .CW(CW)) u_dec (
    .clk_i, .rst_ni,
    .sel_i(bus_sel_i), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .mask_i(bus_wdata_i[N_CH-1:0]),
    .ctrl_we_o(ctrl_we), .cnt_we_o(cnt_we), .duty_we_o(duty_we), .per_we_o(per_we),
    .set_o(set_v), .clr_o(clr_v),
    .ctrl_rd_i(ctrl_v), .cnt_rd_i(cnt_v), .duty_rd_i(duty_v), .per_rd_i(per_v),
    .run_rd_i(run_v), .rdata_o(bus_rdata_o)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    pwm_channel #(.CW(CW)) u_ch (
      .clk_i, .rst_ni,
      .tick_i(tick_i[c]),
      .ctrl_we_i(ctrl_we[c]), .ctrl_wdata_i(ctrl_wdata),
      .cnt_we_i(cnt_we[c]), .duty_we_i(duty_we[c]), .per_we_i(per_we[c]),
      .wdata_i(bus_wdata_i),
      .run_set_i(set_v[c]), .run_clr_i(clr_v[c]),
      .ctrl_o(ctrl_v[c]), .cnt_o(cnt_v[c]), .duty_o(duty_v[c]), .per_o(per_v[c]),
      .run_o(run_v[c]), .pin_o(pwm_o[c])
    );
  end

  p_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_v != '0) |=> ((run_v & $past(set_v)) == $past(set_v)));
  p_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_v != '0) |=> ((run_v & $past(clr_v)) == '0));
  p_untouched_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((run_v ^ $past(run_v)) & ~$past(set_v | clr_v)) == '0));
endmodule

// File: tb/pwm_timer_bank_bench.sv
module pwm_timer_bank_bench;
  localparam int TCLK = 10;
  localparam int N = 8;
  localparam int AW = 6;
  localparam int SET_A = 32;
  localparam int CLR_A = 33;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] tick = '0;
  logic sel = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic [N-1:0] pwm;
  int errors = 0, checks = 0;

  always #(TCLK/2) clk = ~clk;

  pwm_timer_bank u_pwm_timer_bank (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pwm_o(pwm)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); sel = 1; we = 1; addr = AW'(a); wdata = 16'(d);
    @(negedge clk); sel = 0; we = 0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); sel = 1; we = 0; addr = AW'(a);
    #1 d = int'(rdata);
    sel = 0;
  endtask

  // one tick on channels in mask; returns at negedge after the edge
  task automatic tk(input logic [N-1:0] m);
    @(negedge clk); tick = m;
    @(negedge clk); tick = '0;
  endtask

  function automatic int ra(input int ch, input int k);
    return ch*4 + k;
  endfunction

  task automatic t_reset;
    int d;
    chk("R1 pins", int'(pwm), 0);
    rd(SET_A, d); chk("R1 run", d, 0);
    for (int c = 0; c < N; c++) begin
      rd(ra(c,0), d); chk("R1 ctrl", d, 0);
      rd(ra(c,1), d); chk("R1 cnt", d, 0);
    end
  endtask

  task automatic t_count;
    int d;
    wr(ra(2,3), 4); wr(ra(2,2), 2); wr(ra(2,1), 0);
    rd(ra(2,3), d); chk("R11 period readback", d, 4);
    rd(ra(2,2), d); chk("R11 duty readback", d, 2);
    wr(SET_A, 8'h04);
    repeat (3) @(negedge clk);
    rd(ra(2,1), d); chk("R2 hold without tick", d, 0);
    tk(8'h04); rd(ra(2,1), d); chk("R2 step", d, 1);
    tk(8'h01); rd(ra(2,1), d); chk("R2 other tick ignored", d, 1);
    for (int i = 0; i < 3; i++) tk(8'h04);
    rd(ra(2,1), d); chk("R3 at period", d, 4);
    tk(8'h04); rd(ra(2,1), d); chk("R3 wrap to 0", d, 0);
    wr(ra(2,1), 3); rd(ra(2,1), d); chk("R8 counter write", d, 3);
    tk(8'h04); rd(ra(2,1), d); chk("R8 counts from written", d, 4);
    wr(CLR_A, 8'h04);
    tk(8'h04); rd(ra(2,1), d); chk("R2 stopped holds", d, 4);
  endtask

  task automatic t_wave;
    int c = 3, per = 4, duty = 2, cnt = 0;
    wr(ra(c,3), per); wr(ra(c,2), duty); wr(ra(c,1), 0); wr(ra(c,0), 1);
    wr(SET_A, 8'h08);
    chk("R4 start at init", int'(pwm[c]), 0);
    for (int i = 0; i < 11; i++) begin
      tk(8'h08);
      cnt = (cnt == per) ? 0 : cnt + 1;
      chk("R4 waveform", int'(pwm[c]), (cnt >= duty) ? 1 : 0);
    end
    wr(ra(c,0), 5);
    for (int i = 0; i < 6; i++) begin
      tk(8'h08);
      cnt = (cnt == per) ? 0 : cnt + 1;
      chk("R5 init high inverts", int'(pwm[c]), (cnt >= duty) ? 0 : 1);
    end
    wr(CLR_A, 8'h08);
    chk("R5 stopped at init high", int'(pwm[c]), 1);
    wr(ra(c,0), 0);
    chk("R5 stopped at init low", int'(pwm[c]), 0);
  endtask

  task automatic t_over;
    int c = 4;
    wr(ra(c,3), 4); wr(ra(c,2), 7); wr(ra(c,1), 0); wr(ra(c,0), 1);
    wr(SET_A, 8'h10);
    for (int i = 0; i < 12; i++) begin
      tk(8'h10);
      chk("R6 duty above period", int'(pwm[c]), 0);
    end
    wr(ra(c,2), 0);
    tk(8'h10);
    chk("R6 control: duty 0 drives", int'(pwm[c]), 1);
  endtask

  task automatic t_enable;
    int d, base;
    rd(SET_A, base);
    wr(SET_A, 8'h21);
    rd(SET_A, d); chk("R7 set bits", d, base | 8'h21);
    wr(CLR_A, 8'h01);
    rd(SET_A, d); chk("R7 clear one bit", d, (base | 8'h21) & ~8'h01);
    wr(SET_A, 8'h00);
    rd(SET_A, d); chk("R7 zero set no effect", d, (base | 8'h21) & ~8'h01);
    wr(CLR_A, 8'h00);
    rd(SET_A, d); chk("R7 zero clear no effect", d, (base | 8'h21) & ~8'h01);
    // enabled, duty 0, but stopped
    wr(ra(0,3), 3); wr(ra(0,2), 0); wr(ra(0,0), 1);
    chk("R5 enabled but stopped", int'(pwm[0]), 0);
    wr(SET_A, 8'h01);
    chk("R7 start drives", int'(pwm[0]), 1);
    wr(CLR_A, 8'h21);
    rd(SET_A, d); chk("R7 clear two", d, base & ~8'h21);
  endtask

  task automatic t_abrupt;
    int c = 6;
    wr(ra(c,3), 9); wr(ra(c,2), 0); wr(ra(c,1), 0); wr(ra(c,0), 3);
    wr(SET_A, 8'h40);
    tk(8'h40); tk(8'h40);
    chk("R9 running high", int'(pwm[c]), 1);
    wr(ra(c,0), 2);
    chk("R9 abrupt off", int'(pwm[c]), 0);
    tk(8'h40);
    chk("R9 stays off", int'(pwm[c]), 0);
  endtask

  task automatic t_graceful;
    int c = 7;
    wr(ra(c,3), 5); wr(ra(c,2), 1); wr(ra(c,1), 0); wr(ra(c,0), 1);
    wr(SET_A, 8'h80);
    tk(8'h80); tk(8'h80);
    chk("R10 mid period high", int'(pwm[c]), 1);
    wr(ra(c,0), 0);
    chk("R10 still high after clear", int'(pwm[c]), 1);
    for (int i = 0; i < 3; i++) begin
      tk(8'h80);
      chk("R10 period finishes", int'(pwm[c]), 1);
    end
    tk(8'h80);
    chk("R10 init at wrap", int'(pwm[c]), 0);
    tk(8'h80); tk(8'h80);
    chk("R10 stays init next period", int'(pwm[c]), 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_reset();
        t_count();
        t_wave();
        t_over();
        t_enable();
        t_abrupt();
        t_graceful();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule